// File: doc/BRIEF.md
# Byte Table Lookup Unit

This block assembles a 64-bit word one byte lane at a time by table lookup. A packed descriptor names a table made of one to four consecutive 64-bit registers in a 32-entry register file. Each of the eight bytes of an index word picks one byte out of that table. When an index points past the end of the table, the lane takes the matching byte of a separate default word instead.

All eight lanes resolve in parallel against a flattened view of the register file. The result is captured in a register on the edge where the request strobe is high, and a done pulse marks the cycle in which the new result is visible. The block does not write the register file and does no instruction decode. Whatever drives the request supplies the descriptor, the index word, the default word and the current register contents.

Top module: `bytetab_lookup`

## Requirements
- R1: Descriptor bits [1:0] hold the table size minus one, so a table spans 1 to 4 registers. An index byte is in range when it is below the table size times 8.
- R2: Descriptor bits [6:2] hold the number of the first table register.
- R3: Each index lane k occupies bits 8k+7..8k and is treated as an unsigned value from 0 to 255, independently of every other lane.
- R4: An in-range index selects register (first + index[7:3]) and, within that register, byte number index[2:0], where byte 0 is bits 7..0. The selected byte is written to lane k of the result.
- R5: An index at or above the range bound makes lane k of the result equal to lane k of the default word.
- R6: The register number first + index[7:3] wraps modulo 32.
- R7: On a clock edge with `req_valid` high, the result is captured from that cycle's inputs. `res_done` is high for exactly the following cycle.
- R8: On an edge with `req_valid` low, `res_word` keeps its value whatever the other inputs do, and `res_done` is low in the following cycle.
- R9: Synchronous active-high reset clears `res_word` to zero and `res_done` to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; captures a new result |
| req_desc | input | 7 | Packed descriptor: [6:2] first register, [1:0] table size minus one |
| req_index | input | 64 | Eight index bytes, one per result lane |
| req_default | input | 64 | Fallback bytes for out-of-range lanes |
| rf_flat | input | 2048 | Register file contents; register r at bits 64r+63..64r |
| res_word | output | 64 | Registered lookup result |
| res_done | output | 1 | High for the cycle after a captured request |

## Verification
The assertions check the handshake timing on every cycle: done after every strobe, no done and a frozen result without one, and the cleared state after reset. They also check, per lane, that an out-of-range index yields the default byte in the next cycle. Correct byte selection for in-range lanes can only be shown by the bench's scenarios, which compare against a behavioural model. Those scenarios cover every table size, the exact range boundary, register-number wraparound, repeated and mixed index patterns, and back-to-back requests.

// File: rtl/bytetab_pkg.sv
package bytetab_pkg;
  localparam int DEF_DATA_W = 64;
  localparam int DEF_LANE_W = 8;
  localparam int DEF_NREG   = 32;
  localparam int DEF_TLEN_W = 2;

  typedef enum logic {
    SRC_TABLE   = 1'b0,
    SRC_DEFAULT = 1'b1
  } lane_src_e;
endpackage

// File: rtl/bytetab_desc_decode.sv
module bytetab_desc_decode #(
  parameter int TLEN_W = 2,
  parameter int REG_AW = 5,
  localparam int DESC_W = TLEN_W + REG_AW
) (
  input  logic [DESC_W-1:0] desc,
  output logic [REG_AW-1:0] first_reg,
  output logic [TLEN_W:0]   table_regs
);
  assign first_reg  = desc[DESC_W-1:TLEN_W];
  assign table_regs = {1'b0, desc[TLEN_W-1:0]} + {{TLEN_W{1'b0}}, 1'b1};
endmodule

// File: rtl/bytetab_lane.sv
module bytetab_lane
  import bytetab_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int NREG   = 32,
  parameter int TLEN_W = 2,
  localparam int LANES   = DATA_W / LANE_W,
  localparam int BYTE_AW = $clog2(LANES),
  localparam int REG_AW  = $clog2(NREG),
  localparam int OFF_W   = LANE_W - BYTE_AW
) (
  input  logic [LANE_W-1:0]      idx,
  input  logic [REG_AW-1:0]      first_reg,
  input  logic [TLEN_W:0]        table_regs,
  input  logic [NREG*DATA_W-1:0] rf_flat,
  input  logic [LANE_W-1:0]      dflt_byte,
  output logic [LANE_W-1:0]      lane_out
);
  logic [OFF_W-1:0]   reg_off;
  logic [BYTE_AW-1:0] byte_sel;
  logic [REG_AW-1:0]  reg_sel;
  logic [DATA_W-1:0]  word_sel;
  logic [LANE_W-1:0]  table_byte;
  lane_src_e          src;

  assign reg_off  = idx[LANE_W-1:BYTE_AW];
  assign byte_sel = idx[BYTE_AW-1:0];
  // modulo-NREG register number: the sum is truncated to REG_AW bits
  assign reg_sel  = first_reg + REG_AW'(reg_off);
  assign src      = (int'(reg_off) < int'(table_regs)) ? SRC_TABLE : SRC_DEFAULT;

  always_comb begin
    word_sel   = rf_flat[reg_sel*DATA_W +: DATA_W];
    table_byte = word_sel[byte_sel*LANE_W +: LANE_W];
  end

  assign lane_out = (src == SRC_TABLE) ? table_byte : dflt_byte;
endmodule

// File: rtl/bytetab_lookup.sv
module bytetab_lookup
  import bytetab_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int LANE_W = DEF_LANE_W,
  parameter int NREG   = DEF_NREG,
  parameter int TLEN_W = DEF_TLEN_W,
  localparam int LANES  = DATA_W / LANE_W,
  localparam int REG_AW = $clog2(NREG),
  localparam int DESC_W = TLEN_W + REG_AW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [DESC_W-1:0]      req_desc,
  input  logic [DATA_W-1:0]      req_index,
  input  logic [DATA_W-1:0]      req_default,
  input  logic [NREG*DATA_W-1:0] rf_flat,
  output logic [DATA_W-1:0]      res_word,
  output logic                   res_done
);
  logic [REG_AW-1:0] first_reg;
  logic [TLEN_W:0]   table_regs;
  logic [DATA_W-1:0] next_word;

  bytetab_desc_decode #(
    .TLEN_W(TLEN_W),
    .REG_AW(REG_AW)
  ) u_decode (
    .desc      (req_desc),
    .first_reg (first_reg),
    .table_regs(table_regs)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bytetab_lane #(
      .DATA_W(DATA_W),
      .LANE_W(LANE_W),
      .NREG  (NREG),
      .TLEN_W(TLEN_W)
    ) u_lane (
      .idx       (req_index[k*LANE_W +: LANE_W]),
      .first_reg (first_reg),
      .table_regs(table_regs),
      .rf_flat   (rf_flat),
      .dflt_byte (req_default[k*LANE_W +: LANE_W]),
      .lane_out  (next_word[k*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_word <= '0;
      res_done <= 1'b0;
    end else begin
      res_done <= req_valid;
      if (req_valid) res_word <= next_word;
    end
  end
endmodule

// File: rtl/bytetab_checker.sv
module bytetab_checker #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int NREG   = 32,
  parameter int TLEN_W = 2,
  localparam int LANES  = DATA_W / LANE_W,
  localparam int REG_AW = $clog2(NREG),
  localparam int DESC_W = TLEN_W + REG_AW
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   req_valid,
  input logic [DESC_W-1:0]      req_desc,
  input logic [DATA_W-1:0]      req_index,
  input logic [DATA_W-1:0]      req_default,
  input logic [NREG*DATA_W-1:0] rf_flat,
  input logic [DATA_W-1:0]      res_word,
  input logic                   res_done
);
  int bound_c;
  assign bound_c = (int'(req_desc[TLEN_W-1:0]) + 1) * LANES;

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_done); // R7

  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_done); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(res_word)); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (res_word == '0 && !res_done)); // R9

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    AST_OOR_DEFAULT: assert property (@(posedge clk) disable iff (rst)
      (req_valid && int'(req_index[k*LANE_W +: LANE_W]) >= bound_c)
      |=> (res_word[k*LANE_W +: LANE_W] == $past(req_default[k*LANE_W +: LANE_W]))); // R5
  end
endmodule

bind bytetab_lookup bytetab_checker #(
  .DATA_W(DATA_W),
  .LANE_W(LANE_W),
  .NREG  (NREG),
  .TLEN_W(TLEN_W)
) u_chk (.*);

// File: tb/bytetab_lookup_bench.sv
module bytetab_lookup_bench;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [6:0]    req_desc = '0;
  logic [63:0]   req_index = '0;
  logic [63:0]   req_default = '0;
  logic [2047:0] rf_flat;
  logic [63:0]   res_word;
  logic          res_done;

  logic [63:0] rf_mem [32];
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_tag = "R9";
  string exp_tag = "R9";
  logic [63:0] exp_word = '0;
  logic        exp_done = 1'b0;

  always #5 clk = ~clk;

  bytetab_lookup u_bytetab_lookup (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_desc(req_desc),
    .req_index(req_index), .req_default(req_default), .rf_flat(rf_flat),
    .res_word(res_word), .res_done(res_done)
  );

  always_comb
    for (int r = 0; r < 32; r++) rf_flat[r*64 +: 64] = rf_mem[r];

  function automatic logic [63:0] model(input logic [6:0] d, input logic [63:0] ix,
                                        input logic [63:0] df);
    int size, first, idx, r;
    logic [63:0] res;
    size  = int'(d % 4) + 1;
    first = int'(d / 4);
    res = '0;
    for (int k = 0; k < 8; k++) begin
      idx = int'((ix >> (8*k)) & 64'hFF);
      if (idx < size * 8) begin
        r = (first + idx / 8) % 32;
        res = res | (((rf_mem[r] >> (8*(idx % 8))) & 64'hFF) << (8*k));
      end else
        res = res | (df & (64'hFF << (8*k)));
    end
    return res;
  endfunction

  always @(posedge clk) begin
    exp_tag = cur_tag;
    if (rst) begin
      exp_word = '0;
      exp_done = 1'b0;
    end else begin
      exp_done = req_valid;
      if (req_valid) exp_word = model(req_desc, req_index, req_default);
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (res_word !== exp_word || res_done !== exp_done) begin
        errors++;
        $display("FAIL %s: word=%h done=%b expected word=%h done=%b",
                 exp_tag, res_word, res_done, exp_word, exp_done);
      end
    end
  end

  task automatic issue(input logic [6:0] d, input logic [63:0] ix,
                       input logic [63:0] df, input string t);
    cur_tag = t;
    req_desc = d; req_index = ix; req_default = df; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    cur_tag = "R8";
    for (int i = 0; i < n; i++) begin
      req_desc = 7'($urandom); req_index = {$urandom, $urandom};
      req_default = {$urandom, $urandom};
      @(negedge clk);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
    end
  end

  initial begin
    for (int r = 0; r < 32; r++)
      for (int b = 0; b < 8; b++)
        rf_mem[r][8*b +: 8] = 8'((r * 8 + b) ^ 8'h5A);
    repeat (3) @(negedge clk);
    rst = 1'b0;                                   // R9 reset state compared each cycle
    @(negedge clk);
    // R4: single-register table at register 3, each byte in turn
    issue({5'd3, 2'd0}, 64'h0706050403020100, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
    issue({5'd3, 2'd0}, 64'h0001020304050607, 64'h0, "R4");
    // R1: four-register table, indices across all registers
    issue({5'd10, 2'd3}, 64'h1F1E0810_18070F00, 64'h0, "R1");
    // R1/R5 boundary: two registers, index 15 in range, 16 and 255 not
    issue({5'd20, 2'd1}, 64'hFF10_0F10_FF0F_1000, 64'h1122_3344_5566_7788, "R5");
    issue({5'd20, 2'd2}, 64'h1718_1920_2122_2324, 64'hA1A2_A3A4_A5A6_A7A8, "R5");
    // R6: base 30 with 4 registers wraps to 0 and 1
    issue({5'd30, 2'd3}, 64'h1911_1F17_0A02_1820, 64'h0, "R6");
    issue({5'd31, 2'd1}, 64'h0F0E_0D0C_0B0A_0908, 64'h0, "R6");
    // R2: same index with different first registers
    issue({5'd0, 2'd0}, 64'h0302_0100_0706_0504, 64'h0, "R2");
    issue({5'd17, 2'd0}, 64'h0302_0100_0706_0504, 64'h0, "R2");
    // R3: repeated and mixed lanes are independent
    issue({5'd5, 2'd1}, 64'h0909_0909_8080_0909, 64'hDEAD_BEEF_CAFE_F00D, "R3");
    // R8: idle cycles with moving inputs leave the result frozen
    idle(6);
    // R7: back-to-back requests
    for (int i = 0; i < 4; i++)
      issue(7'(i * 9 + 2), {$urandom, $urandom} & 64'h1F1F_1F1F_1F1F_1F1F,
            {$urandom, $urandom}, "R7");
    idle(2);
    // R4 mixed random traffic with table contents changing
    for (int i = 0; i < 300; i++) begin
      if (i % 50 == 0) rf_mem[i % 32] = {$urandom, $urandom};
      if ($urandom % 3 == 0) idle(1);
      else issue(7'($urandom), {$urandom, $urandom} & 64'h3F3F_3F3F_3F3F_3F3F,
                 {$urandom, $urandom}, "R4");
    end
    // R9: reset in the middle of activity
    rst = 1'b1; cur_tag = "R9";
    @(negedge clk);
    rst = 1'b0;
    idle(2);
    summary();
  end
endmodule